// File: doc/BRIEF.md
# Shift, Rotate and Flag Unit

This block performs the single-bit and whole-byte manipulations of an 8-bit datapath. It owns the 8-bit status register. Each accepted command is made of three parts:

- an operand byte;
- a 4-bit operation code;
- a bit index.

For each command the block produces the result byte and a snapshot of the status register after the command. The operations are:

- logical shifts left and right;
- rotates through the carry flag;
- arithmetic shift right;
- nibble swap;
- copying an operand bit into the T flag, and writing T into a result bit;
- forcing any single status bit to 1 or 0.

Commands enter on a valid/ready stream and leave on a second valid/ready stream through a single output register. A command is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. Its result appears on the output one cycle later. The input is ready whenever the output register is empty or is being drained in that same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output holds its contents and no new command is taken. The status register changes at the edge where a command is accepted, so the next command already sees the updated carry and T flags. The current status is also on a plain `status` pin.

Top module: `sfu_top`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An accepted command raises `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, `out_result` and `out_status` stay unchanged.
- R2: Op 0 shifts left and puts 0 into bit 0. Op 1 shifts right and puts 0 into bit 7. The bit shifted out (bit 7 for op 0, bit 0 for op 1) goes to C.
- R3: Op 2 rotates left: the old C enters bit 0 and the old bit 7 goes to C. Op 3 rotates right: the old C enters bit 7 and the old bit 0 goes to C.
- R4: Op 4 shifts bits 7..1 down one place, keeps bit 7, and puts the old bit 0 into C.
- R5: After ops 0 to 4, N is result bit 7, Z is 1 exactly when the result is zero, V is N xor C, and S is N xor V. I, T and H are unchanged.
- R6: Op 5 exchanges the two nibbles of the operand and leaves every status bit unchanged.
- R7: Op 6 copies operand bit `in_idx` into T, returns the operand unchanged, and changes no other status bit.
- R8: Op 7 returns the operand with bit `in_idx` replaced by T and leaves the status unchanged.
- R9: Op 8 sets status bit `in_idx` to 1 and op 9 clears it to 0. Both return the operand unchanged and touch no other status bit.
- R10: The status bit order from bit 7 to bit 0 is I, T, H, S, V, N, Z, C. Reset clears the status register and `out_valid`.
- R11: Op codes 10 to 15 return the operand unchanged and leave the status unchanged.
- R12: A command accepted in the cycle right after another command uses the status produced by that earlier command. The `status` pin shows the updated value from the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Command accepted this cycle if valid |
| in_op | input | 4 | Operation code |
| in_data | input | 8 | Operand byte |
| in_idx | input | 3 | Bit index for bit and flag operations |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | Result byte |
| out_status | output | 8 | Status register after the command |
| status | output | 8 | Live status register |

## Verification
The bench targets the following corner cases:

- **Back-to-back rotates.** A unit that sampled the carry before the preceding command's update would rotate in a stale bit.
- **Arithmetic shift of negative operands.** A logical shift in its place would clear bit 7.
- **Zero results from shifts of 0x80 and 0x01.** A wrong zero or overflow rule would leave Z clear or give V the wrong value.
- **T round trip: store, then load into every bit index.** An off-by-one index, or a T written at the wrong edge, would corrupt the wrong bit.
- **Flag set/clear at index 0 and index 7.** A flipped bit order would move the wrong flag.
- **Stalls under random back-pressure.** A design that let the output change or accepted input while stalled would drop or duplicate results, and the queue-based model catches both.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int SREG_W  = 8;
  localparam int FIDX_W  = 3;
  localparam int OP_W    = 4;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_T = 6;
  localparam int FLG_I = 7;

  typedef enum logic [OP_W-1:0] {
    OP_SHL    = 4'd0,
    OP_SHR    = 4'd1,
    OP_ROLC   = 4'd2,
    OP_RORC   = 4'd3,
    OP_ASHR   = 4'd4,
    OP_SWAP   = 4'd5,
    OP_TSTORE = 4'd6,
    OP_TLOAD  = 4'd7,
    OP_FSET   = 4'd8,
    OP_FCLR   = 4'd9
  } op_e;
endpackage

// File: rtl/sfu_shifter.sv
module sfu_shifter
  import sfu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] d,
  input  op_e               op,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic              flags_upd,
  output logic              hit
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    res       = d;
    cout      = cin;
    flags_upd = 1'b0;
    hit       = 1'b1;
    case (op)
      OP_SHL: begin
        res       = {d[DATA_W-2:0], 1'b0};
        cout      = d[DATA_W-1];
        flags_upd = 1'b1;
      end
      OP_SHR: begin
        res       = {1'b0, d[DATA_W-1:1]};
        cout      = d[0];
        flags_upd = 1'b1;
      end
      OP_ROLC: begin
        res       = {d[DATA_W-2:0], cin};
        cout      = d[DATA_W-1];
        flags_upd = 1'b1;
      end
      OP_RORC: begin
        res       = {cin, d[DATA_W-1:1]};
        cout      = d[0];
        flags_upd = 1'b1;
      end
      OP_ASHR: begin
        res       = {d[DATA_W-1], d[DATA_W-1:1]};
        cout      = d[0];
        flags_upd = 1'b1;
      end
      OP_SWAP: res = {d[HALF-1:0], d[DATA_W-1:HALF]};
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/sfu_bitops.sv
module sfu_bitops #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] d,
  input  logic [IDX_W-1:0]  idx,
  input  logic              t_in,
  input  logic              ld_en,
  output logic [DATA_W-1:0] res,
  output logic              t_bit
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign res[i] = (ld_en && (idx == IDX_W'(i))) ? t_in : d[i];
  end

  assign t_bit = d[idx];
endmodule

// File: rtl/sfu_status.sv
module sfu_status
  import sfu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              flags_upd,
  input  logic [DATA_W-1:0] res,
  input  logic              cout,
  input  logic              t_write,
  input  logic              t_val,
  input  logic              fset,
  input  logic              fclr,
  input  logic [FIDX_W-1:0] fidx,
  output logic [SREG_W-1:0] sreg,
  output logic [SREG_W-1:0] sreg_next
);
  logic [SREG_W-1:0] set_mask, clr_mask;

  for (genvar i = 0; i < SREG_W; i++) begin : g_mask
    assign set_mask[i] = fset && (fidx == FIDX_W'(i));
    assign clr_mask[i] = fclr && (fidx == FIDX_W'(i));
  end

  always_comb begin
    logic n_b, v_b;
    sreg_next = sreg;
    n_b = res[DATA_W-1];
    v_b = n_b ^ cout;
    if (flags_upd) begin
      sreg_next[FLG_C] = cout;
      sreg_next[FLG_Z] = ~|res;
      sreg_next[FLG_N] = n_b;
      sreg_next[FLG_V] = v_b;
      sreg_next[FLG_S] = n_b ^ v_b;
    end
    if (t_write) sreg_next[FLG_T] = t_val;
    sreg_next = (sreg_next & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   sreg <= '0;
    else if (upd) sreg <= sreg_next;
  end

  AST_FLAG_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && fset) |=> ((sreg & $past(set_mask)) == $past(set_mask))); // R9
  AST_FLAG_CLR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && fclr) |=> ((sreg & $past(clr_mask)) == '0)); // R9
  AST_IDLE_KEEPS_SREG: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(sreg)); // R12
endmodule

// File: rtl/sfu_top.sv
module sfu_top
  import sfu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_data,
  input  logic [IDX_W-1:0]  in_idx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [SREG_W-1:0] out_status,
  output logic [SREG_W-1:0] status
);
  op_e               op;
  logic              fire;
  logic [DATA_W-1:0] shf_res, bit_res, result;
  logic              shf_cout, shf_flags, shf_hit, t_bit;
  logic [SREG_W-1:0] sreg, sreg_next;

  assign op       = op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  sfu_shifter #(.DATA_W(DATA_W)) u_shf (
    .d(in_data), .op(op), .cin(sreg[FLG_C]),
    .res(shf_res), .cout(shf_cout), .flags_upd(shf_flags), .hit(shf_hit)
  );

  sfu_bitops #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bit (
    .d(in_data), .idx(in_idx), .t_in(sreg[FLG_T]), .ld_en(op == OP_TLOAD),
    .res(bit_res), .t_bit(t_bit)
  );

  sfu_status #(.DATA_W(DATA_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .upd(fire),
    .flags_upd(shf_flags), .res(shf_res), .cout(shf_cout),
    .t_write(op == OP_TSTORE), .t_val(t_bit),
    .fset(op == OP_FSET), .fclr(op == OP_FCLR), .fidx(FIDX_W'(in_idx)),
    .sreg(sreg), .sreg_next(sreg_next)
  );

  assign result = shf_hit ? shf_res : bit_res;
  assign status = sreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_status <= '0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_result <= result;
      out_status <= sreg_next;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_status))); // R1
  AST_FIRE_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid); // R1
  AST_SHL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_SHL) |=> (status[FLG_C] == $past(in_data[DATA_W-1]))); // R2
  AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && shf_flags) |=> (status[FLG_Z] == (out_result == '0))); // R5
  AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_SWAP) |=> (status == $past(status))); // R6
  AST_TSTORE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_TSTORE) |=> (status[FLG_T] == $past(in_data[in_idx]))); // R7
  AST_TLOAD_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_TLOAD) |=> (status == $past(status))); // R8
endmodule

// File: tb/tb_sfu_top.sv
module tb_sfu_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic [3:0] in_op = '0;
  logic [7:0] in_data = '0;
  logic [2:0] in_idx = '0;
  logic       in_ready, out_valid;
  logic [7:0] out_result, out_status, status;

  sfu_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_data(in_data), .in_idx(in_idx), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_status(out_status),
    .status(status)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] m_sreg = 8'h00;
  logic [19:0] q[$]; // {op, result, status}

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int op, bit flags);
    if (op <= 1) return flags ? "R5" : "R2";
    if (op <= 3) return flags ? "R5" : "R3";
    if (op == 4) return flags ? "R5" : "R4";
    if (op == 5) return "R6";
    if (op == 6) return "R7";
    if (op == 7) return "R8";
    if (op <= 9) return "R9";
    return "R11";
  endfunction

  // behavioural reference: returns {result, new status}
  function automatic logic [15:0] ref_op(int op, logic [7:0] d, int idx, logic [7:0] s);
    logic [7:0] r = d, ns = s;
    bit c = 0, shifted = 1, n, v;
    case (op)
      0: begin r = d << 1; c = d[7]; end
      1: begin r = d >> 1; c = d[0]; end
      2: begin r = (d << 1) | {7'd0, s[0]}; c = d[7]; end
      3: begin r = (d >> 1) | {s[0], 7'd0}; c = d[0]; end
      4: begin r = 8'($signed(d) >>> 1); c = d[0]; end
      default: shifted = 0;
    endcase
    if (shifted) begin
      n = r[7]; v = n ^ c;
      ns[0] = c; ns[1] = (r == 0); ns[2] = n; ns[3] = v; ns[4] = n ^ v;
    end
    case (op)
      5: r = {d[3:0], d[7:4]};
      6: ns[6] = d[idx];
      7: r[idx] = s[6];
      8: ns[idx] = 1'b1;
      9: ns[idx] = 1'b0;
      default: ;
    endcase
    return {r, ns};
  endfunction

  task automatic step(bit v, int op, int d, int idx, bit rdy);
    logic [15:0] e;
    @(negedge clk);
    chk(status == m_sreg, "R12", "status", status, m_sreg);
    chk(out_valid == (q.size() > 0), "R1", "out_valid", out_valid, q.size() > 0);
    if (out_valid && q.size() > 0) begin
      chk(out_result == q[0][15:8], req_of(q[0][19:16], 0), "result", out_result, q[0][15:8]);
      chk(out_status == q[0][7:0], req_of(q[0][19:16], 1), "out_status", out_status, q[0][7:0]);
    end
    in_valid = v; in_op = 4'(op); in_data = 8'(d); in_idx = 3'(idx); out_ready = rdy;
    #1;
    chk(in_ready == (!out_valid || out_ready), "R1", "in_ready", in_ready, !out_valid || out_ready);
    if (out_valid && out_ready && q.size() > 0) void'(q.pop_front());
    if (in_valid && in_ready) begin
      e = ref_op(op, 8'(d), idx, m_sreg);
      q.push_back({4'(op), e});
      m_sreg = e[7:0];
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    step(0, 0, 0, 0, 1);
    chk(status == 8'h00, "R10", "reset status", status, 0);
    chk(out_valid == 1'b0, "R10", "reset out_valid", out_valid, 0);
    // R10: bit order, set I (7) and C (0), clear them again
    step(1, 8, 8'h11, 7, 1); step(1, 8, 8'h22, 0, 1);
    step(0, 0, 0, 0, 1);
    chk(status == 8'h81, "R10", "I and C positions", status, 8'h81);
    step(1, 9, 0, 7, 1); step(1, 9, 0, 0, 1);
    // R2 / R5: zero results from shifts
    step(1, 0, 8'h80, 0, 1); step(1, 1, 8'h01, 0, 1); step(1, 0, 8'h41, 0, 1);
    // R3 / R12: back-to-back rotates chain carry
    step(1, 8, 0, 0, 1);
    step(1, 2, 8'h80, 0, 1); step(1, 3, 8'h01, 0, 1); step(1, 3, 8'h00, 0, 1);
    step(1, 2, 8'h7f, 0, 1);
    // R4: negative and positive operands
    step(1, 4, 8'h81, 0, 1); step(1, 4, 8'hfe, 0, 1); step(1, 4, 8'h40, 0, 1);
    // R6: swap
    step(1, 5, 8'h3c, 0, 1); step(1, 5, 8'ha5, 0, 1);
    // R7 / R8: T round trip into every bit
    for (int i = 0; i < 8; i++) begin
      step(1, 6, 8'h01 << i, i, 1);
      step(1, 7, 8'h00, i, 1);
      step(1, 6, 8'hff ^ (8'h01 << i), i, 1);
      step(1, 7, 8'hff, i, 1);
    end
    // R9: set and clear every flag
    for (int i = 0; i < 8; i++) begin step(1, 8, i, i, 1); step(1, 9, i, i, 1); end
    // R11: reserved codes
    step(1, 8, 0, 5, 1);
    for (int op = 10; op < 16; op++) step(1, op, 8'h5a + op, op & 7, 1);
    // R1: stall with pending result
    step(1, 0, 8'h12, 0, 0); step(1, 1, 8'h34, 0, 0); step(1, 1, 8'h34, 0, 0);
    step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1);
    // random traffic with back-pressure
    for (int k = 0; k < 3000; k++)
      step(($urandom % 4) != 0, $urandom % 16, $urandom % 256, $urandom % 8, ($urandom % 3) != 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule